// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two up-counting timer/counter channels, numbered 0 and 1. Each channel owns a low and a high count byte. The two channels share one mode byte and one control byte. A divide-by-DIV counter makes a machine-cycle tick from the system clock, and every count step lines up with that tick. Each channel counts one of two things: the internal ticks, or falling edges on its own count pin. An external gate pin can hold the channel's counting.

Software selects one of four arrangements for each channel:

- a 13-bit counter, made of a 5-bit prescaler in the low byte under the high byte;
- a plain 16-bit counter;
- an 8-bit counter that reloads its low byte from the high byte;
- a split arrangement, in which channel 0 becomes two independent 8-bit timers and channel 1 halts.

Overflows set sticky flags. These flags are visible on the control byte and on output pins. Every channel-1 overflow also produces a one-cycle strobe, which a serial port can use as its bit-rate source.

A processor reaches the six byte registers through a simple synchronous write port with a combinational read port.

Top module: `tmr_pair`

## Requirements
- R1: A machine tick occurs once every DIV (default 12) clocks. A running channel in timer mode (count-source bit 0) advances exactly once per tick, and at no other time.
- R2: Registers are at these addresses: 0 = mode, 1 = control, 2 = ch0 low, 3 = ch0 high, 4 = ch1 low, 5 = ch1 high. Addresses 6 and 7 read 0.
  - Control bits: [7] ch1 flag, [6] ch1 run, [5] ch0 flag, [4] ch0 run. Bits [3:0] read 0.
  - Mode bits: [7] ch1 gate, [6] ch1 count-source, [5:4] ch1 mode, [3] ch0 gate, [2] ch0 count-source, [1:0] ch0 mode.
  - All registers reset to 0.
- R3: Mode 00 (13-bit counter):
  - Low bits [4:0] count.
  - On their wrap, the high byte increments.
  - The flag sets when the pair wraps from 1FFFh to 0.
  - Low bits [7:5] are left untouched.
- R4: Mode 01 (16-bit counter): high and low bytes form one 16-bit counter. The flag sets on the wrap from FFFFh to 0000h.
- R5: Mode 10 (8-bit auto-reload): the low byte counts. When it is at FFh, the next step loads it from the high byte and sets the flag. The high byte does not change.
- R6: Mode 11 on channel 0 (split):
  - The ch0 low byte counts under ch0 run, gate and source, and sets the ch0 flag at FFh to 00h.
  - The ch0 high byte counts ticks under the ch1 run bit alone, and sets the ch1 flag at FFh to 00h.
  - Mode 11 on channel 1 freezes both ch1 bytes.
- R7: A channel counts only when its run bit is 1 and either its gate bit is 0 or its gate pin is high.
- R8: With count-source 1, a channel advances once for each fall of its count pin. The fall is seen as a high sample followed by a low sample on consecutive ticks.
- R9: Overflow flags are sticky:
  - A control write sets each flag to the written bit.
  - A hardware overflow in the same cycle as a write of 0 wins, and leaves the flag at 1.
- R10: `rate_tick` pulses for one clock after each ch1 overflow. This includes overflows while ch0 is split, although those ch1 overflows do not set the ch1 flag. A ch0 high-byte overflow never pulses `rate_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| gate_pin | input | 2 | Per-channel gate pins, bit n for channel n |
| cnt_pin | input | 2 | Per-channel external count pins |
| ovf_flag | output | 2 | Overflow flags, bit n for channel n |
| rate_tick | output | 1 | One-clock strobe on channel-1 overflow |

## Verification
The bound checker watches, on every cycle, the properties that are purely temporal:

- the tick never lasts two clocks;
- a count byte never changes off a tick unless it is written;
- flags never drop without a control write, and never rise between ticks without a write;
- `rate_tick` is a single-clock pulse that follows a tick;
- a halted channel 1 holds its bytes.

The arithmetic of each mode can only be shown by the directed scenarios. These cover the 13-bit carry, 16-bit wrap, reload value, split counting, gate masking, edge counting, and the write-versus-overflow collision, each with known start values and an exact count of ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_MODE = 3'd0;
    localparam logic [AW-1:0] A_CTRL = 3'd1;
    localparam logic [AW-1:0] A_LO0  = 3'd2;
    localparam logic [AW-1:0] A_HI0  = 3'd3;
    localparam logic [AW-1:0] A_LO1  = 3'd4;
    localparam logic [AW-1:0] A_HI1  = 3'd5;

    typedef enum logic [1:0] {
        MD_PRESC  = 2'b00,
        MD_WIDE   = 2'b01,
        MD_RELOAD = 2'b10,
        MD_SPLIT  = 2'b11
    } tmode_e;

    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
        logic          ovf;
    } step_t;

    typedef struct packed {
        logic [BW-1:0] mode;
        logic          tf1;
        logic          tr1;
        logic          tf0;
        logic          tr0;
        logic [BW-1:0] lo0;
        logic [BW-1:0] hi0;
        logic [BW-1:0] lo1;
        logic [BW-1:0] hi1;
        logic          rate;
    } tstate_t;
endpackage

// File: rtl/tmr_mcdiv.sv
module tmr_mcdiv #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = tick ? pin : prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign fall = tick & prev_q & ~pin;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int DIV   = 12,
    parameter int PRE_W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    input  logic [1:0]    gate_pin,
    input  logic [1:0]    cnt_pin,
    output logic [1:0]    ovf_flag,
    output logic          rate_tick
);
    localparam int SW = BW + PRE_W + 1;
    localparam int WW = 2 * BW + 1;

    tstate_t    st_d, st_q;
    logic       mc_tick;
    logic [1:0] fall;

    tmr_mcdiv #(.DIV(DIV)) u_div (.clk(clk), .rst_n(rst_n), .tick(mc_tick));

    for (genvar ch = 0; ch < 2; ch++) begin : g_edge
        tmr_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (mc_tick),
            .pin  (cnt_pin[ch]),
            .fall (fall[ch])
        );
    end

    function automatic step_t chan_step(input logic [1:0] md, input logic inc,
                                        input logic [BW-1:0] lo, input logic [BW-1:0] hi);
        step_t         r;
        logic [SW-1:0] s13;
        logic [WW-1:0] s16;
        r     = '{lo: lo, hi: hi, ovf: 1'b0};
        s13   = {1'b0, hi, lo[PRE_W-1:0]} + {{(SW-1){1'b0}}, 1'b1};
        s16   = {1'b0, hi, lo} + {{(WW-1){1'b0}}, 1'b1};
        if (inc) begin
            case (tmode_e'(md))
                MD_PRESC: begin
                    r.lo[PRE_W-1:0] = s13[PRE_W-1:0];
                    r.hi            = s13[SW-2:PRE_W];
                    r.ovf           = s13[SW-1];
                end
                MD_WIDE: begin
                    r.lo  = s16[BW-1:0];
                    r.hi  = s16[2*BW-1:BW];
                    r.ovf = s16[WW-1];
                end
                MD_RELOAD: begin
                    r.ovf = &lo;
                    r.lo  = (&lo) ? hi : lo + 1'b1;
                end
                default: ;
            endcase
        end
        return r;
    endfunction

    logic [1:0] md0, md1;
    logic       run0, run1, inc0, inc1, split;
    logic       hw0, hw1;
    step_t      r0, r1;

    always_comb begin
        st_d      = st_q;
        st_d.rate = 1'b0;
        md0   = st_q.mode[1:0];
        md1   = st_q.mode[5:4];
        split = (md0 == MD_SPLIT);
        run0  = st_q.tr0 & (~st_q.mode[3] | gate_pin[0]);
        run1  = st_q.tr1 & (~st_q.mode[7] | gate_pin[1]);
        inc0  = run0 & (st_q.mode[2] ? fall[0] : mc_tick);
        inc1  = run1 & (st_q.mode[6] ? fall[1] : mc_tick);
        hw0   = 1'b0;
        hw1   = 1'b0;
        r0    = chan_step(md0, inc0, st_q.lo0, st_q.hi0);
        r1    = chan_step(md1, inc1, st_q.lo1, st_q.hi1);

        if (split) begin
            if (inc0) begin
                st_d.lo0 = st_q.lo0 + 1'b1;
                hw0      = &st_q.lo0;
            end
            if (mc_tick && st_q.tr1) begin
                st_d.hi0 = st_q.hi0 + 1'b1;
                hw1      = &st_q.hi0;
            end
        end else begin
            st_d.lo0 = r0.lo;
            st_d.hi0 = r0.hi;
            hw0      = r0.ovf;
        end

        if (md1 != MD_SPLIT) begin
            st_d.lo1  = r1.lo;
            st_d.hi1  = r1.hi;
            st_d.rate = r1.ovf;
            if (!split) hw1 = r1.ovf;
        end

        if (wr_en) begin
            case (addr)
                A_MODE: st_d.mode = wdata;
                A_CTRL: begin
                    st_d.tf1 = wdata[7];
                    st_d.tr1 = wdata[6];
                    st_d.tf0 = wdata[5];
                    st_d.tr0 = wdata[4];
                end
                A_LO0: st_d.lo0 = wdata;
                A_HI0: st_d.hi0 = wdata;
                A_LO1: st_d.lo1 = wdata;
                A_HI1: st_d.hi1 = wdata;
                default: ;
            endcase
        end

        st_d.tf0 = st_d.tf0 | hw0;
        st_d.tf1 = st_d.tf1 | hw1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_MODE:  rdata = st_q.mode;
            A_CTRL:  rdata = {st_q.tf1, st_q.tr1, st_q.tf0, st_q.tr0, 4'b0000};
            A_LO0:   rdata = st_q.lo0;
            A_HI0:   rdata = st_q.hi0;
            A_LO1:   rdata = st_q.lo1;
            A_HI1:   rdata = st_q.hi1;
            default: rdata = '0;
        endcase
    end

    assign ovf_flag  = {st_q.tf1, st_q.tf0};
    assign rate_tick = st_q.rate;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic       mc_tick,
    input logic [1:0] ovf_flag,
    input logic       rate_tick,
    input logic [7:0] mode,
    input logic [7:0] lo1,
    input logic [7:0] hi1
);
    logic ctrl_wr, t1_wr;
    assign ctrl_wr = wr_en && (addr == 3'd1);
    assign t1_wr   = wr_en && ((addr == 3'd4) || (addr == 3'd5));

    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick |=> !mc_tick);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !t1_wr) |=> ($stable(lo1) && $stable(hi1)));

    p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[5:4] == 2'b11 && !t1_wr) |=> ($stable(lo1) && $stable(hi1)));

    p_sticky0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag[0] && !ctrl_wr) |=> ovf_flag[0]);

    p_sticky1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag[1] && !ctrl_wr) |=> ovf_flag[1]);

    p_no_rise0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag[0] && !ctrl_wr && !mc_tick) |=> !ovf_flag[0]);

    p_no_rise1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag[1] && !ctrl_wr && !mc_tick) |=> !ovf_flag[1]);

    p_rate_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rate_tick |=> !rate_tick);

    p_rate_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_tick |=> !rate_tick);
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .mc_tick  (mc_tick),
    .ovf_flag (ovf_flag),
    .rate_tick(rate_tick),
    .mode     (st_q.mode),
    .lo1      (st_q.lo1),
    .hi1      (st_q.hi1)
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] gate_pin = '0;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] ovf_flag;
    logic       rate_tick;

    int n_chk = 0;
    int n_bad = 0;
    int rate_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_pair u0 (.*);

    always @(negedge clk) if (rate_tick) rate_cnt++;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // called at a negedge; write lands on the next posedge; returns at the following negedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, {8'h00, rdata}, {8'h00, exp});
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // run bits on for exactly n ticks, flags checked before stopping
    task automatic run_ticks(input logic [7:0] runv, input int n,
                             input string tag, input logic [1:0] exp_flag);
        wr(3'd1, runv);
        wait_n(12 * n - 1);
        chk(tag, {14'd0, ovf_flag}, {14'd0, exp_flag});
        wr(3'd1, 8'h00);
    endtask

    task automatic clear_all();
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        for (int a = 2; a < 6; a++) wr(3'(a), 8'h00);
        gate_pin = 2'b00;
        cnt_pin  = 2'b11;
        wait_n(2);
        rate_cnt = 0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R2 reset value", 3'(a), 8'h00);
        chk("R2 reset flags", {14'd0, ovf_flag}, 16'd0);
        chk("R10 reset strobe", {15'd0, rate_tick}, 16'd0);
        wr(3'd0, 8'hA5);
        rd_chk("R2 mode readback", 3'd0, 8'hA5);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h2F);
        rd_chk("R2 ctrl low bits read 0", 3'd1, 8'h20);
        chk("R9 write 1 sets flag", {14'd0, ovf_flag}, 16'd1);
        wr(3'd1, 8'h00);
        chk("R9 write 0 clears flag", {14'd0, ovf_flag}, 16'd0);
    endtask

    task automatic t_wide();
        clear_all();
        wr(3'd0, 8'h01);
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFD);
        run_ticks(8'h10, 5, "R4 flag after FFFF wrap", 2'b01);
        rd_chk("R4 low after 5 ticks", 3'd2, 8'h02);
        rd_chk("R4 high after wrap", 3'd3, 8'h00);
        rd_chk("R1 ch1 idle", 3'd4, 8'h00);
    endtask

    task automatic t_presc();
        clear_all();
        wr(3'd0, 8'h00);
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFE);
        run_ticks(8'h10, 4, "R3 flag after 1FFF wrap", 2'b01);
        rd_chk("R3 low keeps upper bits", 3'd2, 8'hE2);
        rd_chk("R3 high wrapped", 3'd3, 8'h00);
    endtask

    task automatic t_reload();
        clear_all();
        wr(3'd0, 8'h20);
        wr(3'd5, 8'hF0);
        wr(3'd4, 8'hFE);
        run_ticks(8'h40, 5, "R5 ch1 flag on reload", 2'b10);
        wait_n(3);
        rd_chk("R5 low reloaded and counted", 3'd4, 8'hF3);
        rd_chk("R5 high unchanged", 3'd5, 8'hF0);
        chk("R10 one strobe per ch1 overflow", rate_cnt[15:0], 16'd1);
    endtask

    task automatic t_counter();
        clear_all();
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h10);
        for (int i = 0; i < 3; i++) begin
            cnt_pin[0] = 1'b0; wait_n(36);
            cnt_pin[0] = 1'b1; wait_n(36);
        end
        cnt_pin[0] = 1'b0; wait_n(60);
        wr(3'd1, 8'h00);
        rd_chk("R8 one count per falling edge", 3'd2, 8'h04);
        rd_chk("R8 high untouched", 3'd3, 8'h00);
    endtask

    task automatic t_gate();
        clear_all();
        wr(3'd0, 8'h09);
        wr(3'd1, 8'h10);
        wait_n(119);
        rd_chk("R7 gate low holds count", 3'd2, 8'h00);
        gate_pin[0] = 1'b1;
        wait_n(48);
        gate_pin[0] = 1'b0;
        wait_n(30);
        wr(3'd1, 8'h00);
        rd_chk("R7 counts only while gate high", 3'd2, 8'h04);
    endtask

    task automatic t_split();
        clear_all();
        wr(3'd0, 8'h33);
        wr(3'd2, 8'hFE);
        wr(3'd3, 8'hFD);
        wr(3'd4, 8'h11);
        run_ticks(8'h50, 4, "R6 both flags from split", 2'b11);
        wait_n(3);
        rd_chk("R6 ch0 low in split", 3'd2, 8'h02);
        rd_chk("R6 ch0 high in split", 3'd3, 8'h01);
        rd_chk("R6 halted ch1 low", 3'd4, 8'h11);
        rd_chk("R6 halted ch1 high", 3'd5, 8'h00);
        chk("R10 no strobe from ch0 high", rate_cnt[15:0], 16'd0);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        run_ticks(8'h40, 2, "R6 no flags with ch1 run only", 2'b00);
        rd_chk("R6 high counts on ch1 run", 3'd3, 8'h02);
        rd_chk("R6 low idle on ch1 run", 3'd2, 8'h00);
    endtask

    task automatic t_split_rate();
        clear_all();
        wr(3'd0, 8'h23);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'hFE);
        run_ticks(8'h40, 3, "R10 ch1 overflow hidden in split", 2'b00);
        wait_n(3);
        chk("R10 strobe during split", rate_cnt[15:0], 16'd1);
        rd_chk("R10 ch1 low after reload", 3'd4, 8'hFF);
        rd_chk("R6 ch0 high counted", 3'd3, 8'h03);
    endtask

    task automatic t_collide();
        int k;
        clear_all();
        wr(3'd0, 8'h02);
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'h10);
        k = 0;
        while (!ovf_flag[0] && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk("R9 reload overflow seen", {14'd0, ovf_flag}, 16'd1);
        wr(3'd1, 8'h10);
        chk("R9 clear off tick", {14'd0, ovf_flag}, 16'd0);
        wait_n(10);
        wr(3'd1, 8'h10);
        chk("R9 overflow beats clear", {14'd0, ovf_flag}, 16'd1);
        wr(3'd1, 8'h00);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_wide();
        t_presc();
        t_reload();
        t_counter();
        t_gate();
        t_split();
        t_split_rate();
        t_collide();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule